// File: doc/BRIEF.md
# Debug Link Frame Receiver

This block sits behind the byte receiver of a serial debug link. It takes the incoming byte stream and finds framed messages in it. While idle it waits for the start-of-frame byte. It then gathers the frame header: a 16-bit sequence number, a 32-bit body length and a fixed token byte. After the header it passes the body bytes straight to a streaming output and marks the first and last of them. Finally it checks the 16-bit trailer against a checksum it computes as the bytes arrive. At the end of each frame it gives a single-cycle verdict pulse, either good or bad.

Sideband outputs carry the sequence number of the current frame and a flag for unsolicited event frames. A category decoded from the first body byte tells the consumer what kind of message is arriving before the body is complete. The block never holds back its input, so the downstream logic must accept a body byte in every cycle that one is presented.

Top module: `dbg_frame_rx`

## Requirements
- R1: A synchronous active-high reset returns the receiver to hunting and clears the checksum and counters. After reset, `body_valid`, `frame_good`, `frame_bad` and `cat_valid` are 0, and `in_ready` is 1.
- R2: While hunting, every accepted byte other than 0x1B is discarded with no effect on any output. The byte 0x1B starts a frame.
- R3: The two bytes that follow the start byte form the sequence number, low byte first. It appears on `seq_num` once both bytes are in. `seq_event` is 1 exactly when that value is 0xFFFF.
- R4: The byte that follows the four length bytes must be 0x0E. Any other value gives a `frame_bad` pulse in the cycle after that byte, and the receiver goes back to hunting.
- R5: The length is four bytes, low byte first, and counts body bytes only. If it exceeds MAX_LEN (default 100000), `frame_bad` pulses in the cycle after the fourth length byte and the receiver goes back to hunting. A length equal to MAX_LEN is accepted.
- R6: Each body byte appears on `body_data` with `body_valid` one cycle after it is accepted. `body_first` marks the first body byte and `body_last` marks the byte at position length. For a one-byte body both markers are set in the same cycle.
- R7: The first body byte is classified and reported on `cat` with `cat_valid` in the same cycle as `body_first`. The codes are: 0x00-0x3F gives 0 (command), 0x40-0x7F gives 1 (internal), 0x80-0x9F gives 2 (success), 0xA0-0xBF gives 3 (failure), 0xC0-0xDF gives 4 (undefined) and 0xE0-0xFF gives 5 (event). The category is held until the next start byte.
- R8: A length of zero moves straight from the token byte to the two checksum bytes. No body byte is emitted, and `cat_valid` stays 0 for that frame.
- R9: The checksum is reflected CRC-16 with polynomial 0x8408, initial value 0xFFFF and no final inversion. It covers the start byte through the last body byte and is sent low byte first. A match gives a `frame_good` pulse and a mismatch gives a `frame_bad` pulse, in the cycle after the second checksum byte. The two pulses are never set together.
- R10: A cycle with `in_valid` low does not advance the receiver. No body byte or verdict follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Incoming link byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Byte accepted (always 1) |
| body_data | output | 8 | Streamed body byte |
| body_valid | output | 1 | `body_data` holds a body byte |
| body_first | output | 1 | First body byte of the frame |
| body_last | output | 1 | Last body byte of the frame |
| frame_good | output | 1 | Frame ended with matching checksum |
| frame_bad | output | 1 | Frame rejected (token, length or checksum) |
| seq_num | output | 16 | Sequence number of the current frame |
| seq_event | output | 1 | Current frame is an unsolicited event frame |
| cat | output | 3 | Category code of the first body byte |
| cat_valid | output | 1 | `cat` belongs to the current frame |

## Verification
With a one-byte body, the start of the stream, the end of the stream and the classification all happen on the same beat. The bench sends one-byte frames whose single body byte covers every category range, including an event frame with sequence 0xFFFF. For each of these it checks that `body_first`, `body_last` and `cat_valid` are high in the same sampled cycle, and that `cat` has the expected code. The verdict pulse two bytes later must still be `frame_good`, which shows that the checksum covered that lone byte correctly.

// File: rtl/dbg_frame_rx_pkg.sv
package dbg_frame_rx_pkg;

    localparam logic [7:0] SOF_BYTE   = 8'h1B;
    localparam logic [7:0] TOKEN_BYTE = 8'h0E;
    localparam logic [15:0] EVT_SEQ   = 16'hFFFF;
    localparam logic [15:0] CRC_INIT  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY  = 16'h8408;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SEQ,
        ST_LEN,
        ST_TOK,
        ST_BODY,
        ST_CRC
    } rx_state_t;

    typedef enum logic [2:0] {
        CAT_CMD   = 3'd0,
        CAT_INT   = 3'd1,
        CAT_OK    = 3'd2,
        CAT_FAIL  = 3'd3,
        CAT_UNDEF = 3'd4,
        CAT_EVT   = 3'd5
    } msg_cat_t;

endpackage

// File: rtl/dbg_crc16_byte.sv
module dbg_crc16_byte #(
    parameter int          BYTE_W = 8,
    parameter logic [15:0] POLY   = 16'h8408
) (
    input  logic [15:0]       crc_in,
    input  logic [BYTE_W-1:0] data,
    output logic [15:0]       crc_out
);
    logic [15:0] stage [BYTE_W+1];

    assign stage[0] = crc_in ^ {{(16-BYTE_W){1'b0}}, data};

    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY)
                                        :  (stage[i] >> 1);
    end

    assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/dbg_msg_classify.sv
module dbg_msg_classify
    import dbg_frame_rx_pkg::*;
(
    input  logic [7:0] code,
    output msg_cat_t   cat
);
    always_comb begin
        unique casez (code[7:5])
            3'b00?:  cat = CAT_CMD;
            3'b01?:  cat = CAT_INT;
            3'b100:  cat = CAT_OK;
            3'b101:  cat = CAT_FAIL;
            3'b110:  cat = CAT_UNDEF;
            default: cat = CAT_EVT;
        endcase
    end
endmodule

// File: rtl/dbg_frame_rx.sv
module dbg_frame_rx
    import dbg_frame_rx_pkg::*;
#(
    parameter int MAX_LEN = 100000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [7:0]  body_data,
    output logic        body_valid,
    output logic        body_first,
    output logic        body_last,
    output logic        frame_good,
    output logic        frame_bad,
    output logic [15:0] seq_num,
    output logic        seq_event,
    output logic [2:0]  cat,
    output logic        cat_valid
);
    localparam int LEN_W = 32;
    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

    typedef struct packed {
        rx_state_t        st;
        logic [1:0]       idx;
        logic [7:0]       lo_hold;
        logic [15:0]      seq;
        logic             seq_evt;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] rem;
        logic             first;
        logic [15:0]      crc;
        logic [7:0]       bdata;
        logic             bvalid;
        logic             bfirst;
        logic             blast;
        logic             good;
        logic             bad;
        msg_cat_t         cat;
        logic             cat_v;
    } rx_regs_t;

    localparam rx_regs_t RESET_VAL = '{
        st: ST_HUNT, idx: 2'd0, lo_hold: 8'd0, seq: 16'd0, seq_evt: 1'b0,
        len: '0, rem: '0, first: 1'b0, crc: CRC_INIT, bdata: 8'd0,
        bvalid: 1'b0, bfirst: 1'b0, blast: 1'b0, good: 1'b0, bad: 1'b0,
        cat: CAT_CMD, cat_v: 1'b0
    };

    rx_regs_t    q, d;
    logic [15:0] crc_seed, crc_next;
    msg_cat_t    cat_now;
    logic [LEN_W-1:0] len_full;

    assign crc_seed = (q.st == ST_HUNT) ? CRC_INIT : q.crc;
    assign len_full = {in_data, q.len[23:0]};

    dbg_crc16_byte #(.BYTE_W(8), .POLY(CRC_POLY)) u_crc (
        .crc_in (crc_seed),
        .data   (in_data),
        .crc_out(crc_next)
    );

    dbg_msg_classify u_cls (
        .code(in_data),
        .cat (cat_now)
    );

    always_comb begin
        d        = q;
        d.bvalid = 1'b0;
        d.bfirst = 1'b0;
        d.blast  = 1'b0;
        d.good   = 1'b0;
        d.bad    = 1'b0;
        if (in_valid) begin
            unique case (q.st)
                ST_HUNT: begin
                    if (in_data == SOF_BYTE) begin
                        d.st    = ST_SEQ;
                        d.idx   = 2'd0;
                        d.crc   = crc_next;
                        d.cat_v = 1'b0;
                    end
                end
                ST_SEQ: begin
                    d.crc = crc_next;
                    if (q.idx == 2'd0) begin
                        d.lo_hold = in_data;
                        d.idx     = 2'd1;
                    end else begin
                        d.seq     = {in_data, q.lo_hold};
                        d.seq_evt = ({in_data, q.lo_hold} == EVT_SEQ);
                        d.st      = ST_LEN;
                        d.idx     = 2'd0;
                    end
                end
                ST_LEN: begin
                    d.crc = crc_next;
                    d.idx = q.idx + 2'd1;
                    unique case (q.idx)
                        2'd0: d.len[7:0]   = in_data;
                        2'd1: d.len[15:8]  = in_data;
                        2'd2: d.len[23:16] = in_data;
                        default: begin
                            d.len = len_full;
                            if (len_full > LEN_LIMIT) begin
                                d.bad = 1'b1;
                                d.st  = ST_HUNT;
                            end else begin
                                d.st  = ST_TOK;
                            end
                        end
                    endcase
                end
                ST_TOK: begin
                    d.crc   = crc_next;
                    d.idx   = 2'd0;
                    d.rem   = q.len;
                    d.first = 1'b1;
                    if (in_data != TOKEN_BYTE) begin
                        d.bad = 1'b1;
                        d.st  = ST_HUNT;
                    end else if (q.len == '0) begin
                        d.st  = ST_CRC;
                    end else begin
                        d.st  = ST_BODY;
                    end
                end
                ST_BODY: begin
                    d.crc    = crc_next;
                    d.bdata  = in_data;
                    d.bvalid = 1'b1;
                    d.bfirst = q.first;
                    d.blast  = (q.rem == LEN_W'(1));
                    d.first  = 1'b0;
                    d.rem    = q.rem - LEN_W'(1);
                    if (q.first) begin
                        d.cat   = cat_now;
                        d.cat_v = 1'b1;
                    end
                    if (q.rem == LEN_W'(1)) begin
                        d.st  = ST_CRC;
                        d.idx = 2'd0;
                    end
                end
                default: begin
                    if (q.idx == 2'd0) begin
                        d.lo_hold = in_data;
                        d.idx     = 2'd1;
                    end else begin
                        d.good = ({in_data, q.lo_hold} == q.crc);
                        d.bad  = ({in_data, q.lo_hold} != q.crc);
                        d.st   = ST_HUNT;
                        d.idx  = 2'd0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RESET_VAL;
        else     q <= d;
    end

    assign in_ready   = 1'b1;
    assign body_data  = q.bdata;
    assign body_valid = q.bvalid;
    assign body_first = q.bfirst;
    assign body_last  = q.blast;
    assign frame_good = q.good;
    assign frame_bad  = q.bad;
    assign seq_num    = q.seq;
    assign seq_event  = q.seq_evt;
    assign cat        = q.cat;
    assign cat_valid  = q.cat_v;
endmodule

// File: rtl/dbg_frame_rx_chk.sv
module dbg_frame_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        body_valid,
    input logic        body_first,
    input logic        body_last,
    input logic        frame_good,
    input logic        frame_bad,
    input logic [15:0] seq_num,
    input logic        seq_event,
    input logic        cat_valid
);
    p_verdict_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(frame_good && frame_bad));

    p_good_single_r9: assert property (@(posedge clk) disable iff (rst)
        frame_good |=> !frame_good);

    p_last_in_stream_r6: assert property (@(posedge clk) disable iff (rst)
        body_last |-> body_valid);

    p_first_in_stream_r6: assert property (@(posedge clk) disable iff (rst)
        body_first |-> body_valid);

    p_first_has_cat_r7: assert property (@(posedge clk) disable iff (rst)
        body_first |-> cat_valid);

    p_event_seq_r3: assert property (@(posedge clk) disable iff (rst)
        seq_event |-> (seq_num == 16'hFFFF));

    p_idle_no_output_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!body_valid && !frame_good && !frame_bad));
endmodule

bind dbg_frame_rx dbg_frame_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .body_valid(body_valid),
    .body_first(body_first),
    .body_last (body_last),
    .frame_good(frame_good),
    .frame_bad (frame_bad),
    .seq_num   (seq_num),
    .seq_event (seq_event),
    .cat_valid (cat_valid)
);

// File: tb/dbg_frame_rx_test.sv
module dbg_frame_rx_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_data = 8'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  body_data;
    logic        body_valid, body_first, body_last;
    logic        frame_good, frame_bad;
    logic [15:0] seq_num;
    logic        seq_event;
    logic [2:0]  cat;
    logic        cat_valid;

    int checks = 0;
    int errors = 0;

    // per-frame observation
    int         n_body, n_first, n_last, n_good, n_bad, n_both, n_data_err;
    logic [2:0] seen_cat;
    logic       seen_catv;
    logic [7:0] exp_body [32];

    always #4 clk = ~clk;

    dbg_frame_rx uut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .body_data(body_data), .body_valid(body_valid),
        .body_first(body_first), .body_last(body_last),
        .frame_good(frame_good), .frame_bad(frame_bad), .seq_num(seq_num),
        .seq_event(seq_event), .cat(cat), .cat_valid(cat_valid)
    );

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c ^ {8'd0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    task automatic clear_obs();
        n_body = 0; n_first = 0; n_last = 0; n_good = 0; n_bad = 0;
        n_both = 0; n_data_err = 0; seen_catv = 1'b0; seen_cat = 3'd7;
    endtask

    // called at a negedge; returns at the following negedge with outputs sampled
    task automatic send_byte(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        if (body_valid) begin
            if (body_data != exp_body[n_body % 32]) n_data_err++;
            n_body++;
        end
        if (body_first) begin
            n_first++;
            seen_cat  = cat;
            seen_catv = cat_valid;
        end
        if (body_last) n_last++;
        if (body_first && body_last) n_both++;
        if (frame_good) n_good++;
        if (frame_bad) n_bad++;
    endtask

    task automatic send_frame(input logic [15:0] seq, input int len,
                              input logic [7:0] b0, input logic corrupt);
        logic [15:0] c = 16'hFFFF;
        logic [7:0]  hdr [8];
        hdr = '{8'h1B, seq[7:0], seq[15:8], 8'(len), 8'(len >> 8),
                8'(len >> 16), 8'(len >> 24), 8'h0E};
        clear_obs();
        for (int i = 0; i < 8; i++) begin
            c = crc_step(c, hdr[i]);
            send_byte(hdr[i]);
        end
        for (int i = 0; i < len; i++) exp_body[i % 32] = b0 + 8'(i);
        for (int i = 0; i < len; i++) begin
            c = crc_step(c, b0 + 8'(i));
            send_byte(b0 + 8'(i));
        end
        if (corrupt) c = c ^ 16'h0100;
        send_byte(c[7:0]);
        send_byte(c[15:8]);
    endtask

    task automatic t_reset();
        check(!body_valid && !frame_good && !frame_bad && !cat_valid, "R1 reset outputs",
              {body_valid, frame_good, frame_bad, cat_valid}, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    endtask

    task automatic t_hunt();
        clear_obs();
        send_byte(8'h00); send_byte(8'h0E); send_byte(8'hFF); send_byte(8'h1A);
        check(n_body + n_good + n_bad == 0, "R2 garbage ignored", n_body + n_good + n_bad, 0);
        check(!cat_valid, "R2 cat untouched", cat_valid, 0);
    endtask

    task automatic t_good();
        send_frame(16'h1234, 3, 8'h05, 1'b0);
        check(n_good == 1 && n_bad == 0, "R9 good verdict", n_good, 1);
        check(seq_num == 16'h1234, "R3 seq captured", seq_num, 16'h1234);
        check(!seq_event, "R3 not event", seq_event, 0);
        check(n_body == 3 && n_data_err == 0, "R6 body stream", n_body, 3);
        check(n_first == 1 && n_last == 1 && n_both == 0, "R6 markers", n_first * 16 + n_last, 17);
        check(seen_catv && seen_cat == 3'd0, "R7 command category", seen_cat, 0);
    endtask

    task automatic t_single(input logic [15:0] seq, input logic [7:0] code, input logic [2:0] ec);
        send_frame(seq, 1, code, 1'b0);
        check(n_both == 1, "R6 R7 first and last together", n_both, 1);
        check(seen_catv && seen_cat == ec, "R7 category", seen_cat, ec);
        check(n_good == 1, "R9 single byte good", n_good, 1);
    endtask

    task automatic t_event();
        t_single(16'hFFFF, 8'hE0, 3'd5);
        check(seq_event && seq_num == 16'hFFFF, "R3 event frame", seq_num, 16'hFFFF);
    endtask

    task automatic t_zero();
        send_frame(16'h0007, 0, 8'h00, 1'b0);
        check(n_body == 0, "R8 no body bytes", n_body, 0);
        check(!cat_valid, "R8 cat invalid", cat_valid, 0);
        check(n_good == 1, "R8 zero length good", n_good, 1);
    endtask

    task automatic t_badcrc();
        send_frame(16'h0042, 2, 8'h81, 1'b1);
        check(n_bad == 1 && n_good == 0, "R9 checksum mismatch", n_bad, 1);
    endtask

    task automatic t_badtoken();
        clear_obs();
        send_byte(8'h1B); send_byte(8'h01); send_byte(8'h00);
        send_byte(8'h02); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        check(n_bad == 0, "R4 no early verdict", n_bad, 0);
        send_byte(8'h0F);
        check(n_bad == 1, "R4 token rejected", n_bad, 1);
        send_frame(16'h0099, 2, 8'h44, 1'b0);
        check(n_good == 1 && n_body == 2, "R4 back to hunting", n_good, 1);
    endtask

    task automatic t_stall();
        logic [15:0] c = 16'hFFFF;
        logic [7:0]  fr [10];
        int          idle_bad;
        fr = '{8'h1B, 8'h10, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0E, 8'h90, 8'h00};
        for (int i = 0; i < 9; i++) c = crc_step(c, fr[i]);
        clear_obs();
        idle_bad = 0;
        exp_body[0] = 8'h90;
        for (int i = 0; i < 9; i++) begin
            send_byte(fr[i]);
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                if (body_valid || frame_good || frame_bad) idle_bad++;
            end
        end
        send_byte(c[7:0]);
        @(negedge clk);
        if (body_valid || frame_good || frame_bad) idle_bad++;
        send_byte(c[15:8]);
        check(idle_bad == 0, "R10 idle cycles inert", idle_bad, 0);
        check(n_good == 1 && n_body == 1 && seen_cat == 3'd2, "R10 stalled frame good", n_good, 1);
    endtask

    task automatic t_oversize();
        clear_obs();
        send_byte(8'h1B); send_byte(8'h00); send_byte(8'h00);
        send_byte(8'hA1); send_byte(8'h86); send_byte(8'h01);   // 100001
        check(n_bad == 0, "R5 no verdict before last length byte", n_bad, 0);
        send_byte(8'h00);
        check(n_bad == 1, "R5 oversize rejected", n_bad, 1);
        send_byte(8'h0E);
        check(n_bad == 1 && n_body == 0, "R5 returned to hunting", n_bad, 1);
        clear_obs();
        send_byte(8'h1B); send_byte(8'h00); send_byte(8'h00);
        send_byte(8'hA0); send_byte(8'h86); send_byte(8'h01); send_byte(8'h00); // 100000
        send_byte(8'h0E);
        check(n_bad == 0, "R5 limit length accepted", n_bad, 0);
        exp_body[0] = 8'h33;
        send_byte(8'h33);
        check(n_body == 1 && n_first == 1, "R5 body starts at limit length", n_body, 1);
    endtask

    task automatic t_reset_mid();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        send_frame(16'h0001, 1, 8'h20, 1'b0);
        check(n_good == 1, "R1 clean restart after reset", n_good, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hunt();
        t_good();
        t_event();
        t_single(16'h0002, 8'h40, 3'd1);
        t_single(16'h0003, 8'h9F, 3'd2);
        t_single(16'h0004, 8'hA0, 3'd3);
        t_single(16'h0005, 8'hC0, 3'd4);
        t_single(16'h0006, 8'h3F, 3'd0);
        t_zero();
        t_badcrc();
        t_badtoken();
        t_stall();
        t_oversize();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule